// File: doc/BRIEF.md
# Chunked Outbound Address Window Decoder

This block sits between a CPU-side system bus and a PCI host bridge. It decides for each CPU address whether the bridge should claim the access and forward it into PCI memory space. It also sorts addresses that PCI bus masters present into those that reach system memory and those that stay in PCI memory. The top 256 MB of the 4 GB space, starting at 0xF0000000, is split into 32 chunks of 8 MB each. Chunk i starts at 0xF0000000 + i*8 MB and is selected by address bits [27:23].

Each chunk has its own bit in a 32-bit enable register. A two-bit mode field in a control register switches all chunks on or off together. The lowest chunk holds the boot firmware and the highest chunk holds the bridge's own registers, so neither can ever be enabled. A forwarded access keeps its address unchanged in PCI space. Software programs both registers through a simple word-wide write port and reads them back through a registered read port.

Top module: `chunk_window_decoder`

## Requirements
- R1: While reset is asserted and after it is released, both registers read as zero and no access is claimed. The forwarding mode is therefore off after reset.
- R2: A write to offset 0x060 stores the written data ANDed with 0x7FFFFFFE. Reading offset 0x060 returns the stored value, with bits 0 and 31 always zero.
- R3: A write to offset 0x038 stores all 32 bits of the control register, and reading offset 0x038 returns them unchanged. Read data appears on cfg_rdata one clock after cfg_addr is sampled.
- R4: A valid CPU access is claimed when three conditions hold: control bits [8:7] equal 2'b01, address bits [31:28] equal 4'hF, and the enable bit selected by address bits [27:23] is set. fwd_claim rises one clock after cpu_valid, and fwd_addr carries the address unchanged.
- R5: When control bits [8:7] are 2'b00, 2'b10 or 2'b11, no access is claimed, whatever the enable register holds.
- R6: Accesses to chunk 0 (0xF0000000 to 0xF07FFFFF) and chunk 31 (0xFF800000 to 0xFFFFFFFF) are never claimed, even after all ones is written to the enable register.
- R7: Addresses below 0xF0000000 are never claimed.
- R8: A register write takes effect for a CPU access presented in the very next clock. Clearing an enable bit stops claims in that chunk from the next access on.
- R9: A valid bus-master address below 0xF0800000 raises bm_to_sys, and any address from 0xF0800000 upward raises bm_to_pci. The flags appear one clock after bm_valid, bm_addr_out carries the address unchanged, and the two flags are never high together.
- R10: A CPU address presented without cpu_valid is never claimed.
- R11: Writes to any offset other than 0x038 and 0x060 change neither register. Reads of such an offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the offset sampled on the previous clock |
| cpu_valid | input | 1 | CPU address valid |
| cpu_addr | input | 32 | CPU-side address |
| fwd_claim | output | 1 | Access is forwarded to PCI memory (registered) |
| fwd_addr | output | 32 | Address in PCI memory space (registered) |
| bm_valid | input | 1 | Bus-master address valid |
| bm_addr | input | 32 | Bus-master address from PCI |
| bm_to_sys | output | 1 | Bus-master access is routed to system memory (registered) |
| bm_to_pci | output | 1 | Bus-master access is routed to PCI memory (registered) |
| bm_addr_out | output | 32 | Routed bus-master address (registered) |

## Verification
The outbound decode is exercised with several address patterns. Chunks 1, 22 and 30 are tried with their own enable bit set, which checks that the chunk index is decoded correctly, and neighbouring chunks are tried with their bits clear, which catches an off-by-one in the index. The two masked edge chunks are tried with every enable bit written to one. Addresses whose chunk bits match an enabled chunk but whose top nibble is not F show whether the region tag is compared at all. Every value of the mode field is tried, including a control word full of unrelated set bits, which shows that only bits [8:7] gate forwarding. The inbound split is probed on both sides of 0xF0800000 and at the two ends of the address space.

// File: rtl/chunk_dec_pkg.sv
package chunk_dec_pkg;

  typedef enum logic [1:0] {
    FWD_OFF   = 2'b00,
    FWD_ON    = 2'b01,
    FWD_RSVD2 = 2'b10,
    FWD_RSVD3 = 2'b11
  } fwd_mode_e;

  function automatic logic mode_active(input logic [1:0] mode);
    return fwd_mode_e'(mode) == FWD_ON;
  endfunction

endpackage

// File: rtl/cdec_regs.sv
module cdec_regs #(
  parameter int DATA_W     = 32,
  parameter int OFF_W      = 12,
  parameter int NUM_CHUNKS = 32,
  parameter logic [OFF_W-1:0] CTRL_OFF = 12'h038,
  parameter logic [OFF_W-1:0] EN_OFF   = 12'h060
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [OFF_W-1:0]      addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     ctrl_q,
  output logic [NUM_CHUNKS-1:0] en_q,
  output logic [DATA_W-1:0]     rdata
);
  // The first and the last chunk can never be enabled.
  localparam logic [NUM_CHUNKS-1:0] LOW_BIT  = NUM_CHUNKS'(1);
  localparam logic [NUM_CHUNKS-1:0] HIGH_BIT = LOW_BIT << (NUM_CHUNKS - 1);
  localparam logic [NUM_CHUNKS-1:0] EN_MASK  = ~(LOW_BIT | HIGH_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      en_q   <= '0;
    end else if (we) begin
      if (addr == CTRL_OFF) ctrl_q <= wdata;
      if (addr == EN_OFF)   en_q   <= wdata[NUM_CHUNKS-1:0] & EN_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (addr)
        CTRL_OFF: rdata <= ctrl_q;
        EN_OFF:   rdata <= DATA_W'(en_q);
        default:  rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/cdec_outbound.sv
module cdec_outbound #(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_SHIFT = 23,
  parameter int NUM_CHUNKS  = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'hF000_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            mode,
  input  logic [NUM_CHUNKS-1:0] en,
  output logic                  claim,
  output logic [ADDR_W-1:0]     pci_addr
);
  import chunk_dec_pkg::*;

  localparam int IDX_W = $clog2(NUM_CHUNKS);
  localparam int TAG_W = ADDR_W - CHUNK_SHIFT - IDX_W;
  localparam logic [TAG_W-1:0] REGION_TAG = REGION_BASE[ADDR_W-1 -: TAG_W];

  logic [IDX_W-1:0]      idx;
  logic                  in_region;
  logic [NUM_CHUNKS-1:0] hit;
  logic                  claim_d;

  assign idx       = addr[CHUNK_SHIFT +: IDX_W];
  assign in_region = addr[ADDR_W-1 -: TAG_W] == REGION_TAG;

  for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_chunk
    assign hit[i] = en[i] && (idx == IDX_W'(i));
  end

  assign claim_d = valid && in_region && mode_active(mode) && (|hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      claim    <= 1'b0;
      pci_addr <= '0;
    end else begin
      claim <= claim_d;
      if (valid) pci_addr <= addr;
    end
  end

endmodule

// File: rtl/cdec_inbound.sv
module cdec_inbound #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] SPLIT = 32'hF080_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              to_sys,
  output logic              to_pci,
  output logic [ADDR_W-1:0] addr_out
);
  logic below;
  assign below = addr < SPLIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      to_sys   <= 1'b0;
      to_pci   <= 1'b0;
      addr_out <= '0;
    end else begin
      to_sys <= valid && below;
      to_pci <= valid && !below;
      if (valid) addr_out <= addr;
    end
  end

endmodule

// File: rtl/chunk_window_decoder.sv
module chunk_window_decoder #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int OFF_W       = 12,
  parameter int CHUNK_SHIFT = 23,
  parameter int NUM_CHUNKS  = 32,
  parameter int MODE_LSB    = 7,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'hF000_0000,
  parameter logic [OFF_W-1:0]  CTRL_OFF    = 12'h038,
  parameter logic [OFF_W-1:0]  EN_OFF      = 12'h060
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [OFF_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              fwd_claim,
  output logic [ADDR_W-1:0] fwd_addr,
  input  logic              bm_valid,
  input  logic [ADDR_W-1:0] bm_addr,
  output logic              bm_to_sys,
  output logic              bm_to_pci,
  output logic [ADDR_W-1:0] bm_addr_out
);
  // Inbound traffic goes to PCI memory from the first forwardable chunk up.
  localparam logic [ADDR_W-1:0] CHUNK_SIZE = ADDR_W'(1) << CHUNK_SHIFT;
  localparam logic [ADDR_W-1:0] SPLIT      = REGION_BASE + CHUNK_SIZE;

  logic [DATA_W-1:0]     ctrl_q;
  logic [NUM_CHUNKS-1:0] en_q;

  cdec_regs #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .NUM_CHUNKS(NUM_CHUNKS),
    .CTRL_OFF(CTRL_OFF), .EN_OFF(EN_OFF)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl_q(ctrl_q), .en_q(en_q), .rdata(cfg_rdata)
  );

  cdec_outbound #(
    .ADDR_W(ADDR_W), .CHUNK_SHIFT(CHUNK_SHIFT), .NUM_CHUNKS(NUM_CHUNKS),
    .REGION_BASE(REGION_BASE)
  ) u_out (
    .clk(clk), .rst(rst), .valid(cpu_valid), .addr(cpu_addr),
    .mode(ctrl_q[MODE_LSB +: 2]), .en(en_q),
    .claim(fwd_claim), .pci_addr(fwd_addr)
  );

  cdec_inbound #(
    .ADDR_W(ADDR_W), .SPLIT(SPLIT)
  ) u_in (
    .clk(clk), .rst(rst), .valid(bm_valid), .addr(bm_addr),
    .to_sys(bm_to_sys), .to_pci(bm_to_pci), .addr_out(bm_addr_out)
  );

endmodule

// File: rtl/chunk_window_decoder_chk.sv
module chunk_window_decoder_chk #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CHUNK_SHIFT = 23,
  parameter int NUM_CHUNKS  = 32,
  parameter int MODE_LSB    = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cpu_valid,
  input logic [ADDR_W-1:0]     cpu_addr,
  input logic                  fwd_claim,
  input logic [ADDR_W-1:0]     fwd_addr,
  input logic                  bm_valid,
  input logic                  bm_to_sys,
  input logic                  bm_to_pci,
  input logic [DATA_W-1:0]     ctrl_q,
  input logic [NUM_CHUNKS-1:0] en_q
);
  localparam int IDX_W = $clog2(NUM_CHUNKS);
  localparam int TAG_W = ADDR_W - CHUNK_SHIFT - IDX_W;

  assert_edge_bits_masked_R2: assert property (@(posedge clk) disable iff (rst)
    !en_q[0] && !en_q[NUM_CHUNKS-1]);

  assert_claim_addr_kept_R4: assert property (@(posedge clk) disable iff (rst)
    fwd_claim |-> fwd_addr == $past(cpu_addr));

  assert_claim_needs_mode_R5: assert property (@(posedge clk) disable iff (rst)
    fwd_claim |-> $past(ctrl_q[MODE_LSB +: 2]) == 2'b01);

  assert_no_edge_chunk_R6: assert property (@(posedge clk) disable iff (rst)
    fwd_claim |-> ($past(cpu_addr[CHUNK_SHIFT +: IDX_W]) != '0) &&
                  ($past(cpu_addr[CHUNK_SHIFT +: IDX_W]) != '1));

  assert_no_low_claim_R7: assert property (@(posedge clk) disable iff (rst)
    fwd_claim |-> $past(cpu_addr[ADDR_W-1 -: TAG_W]) == '1);

  assert_inbound_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bm_to_sys, bm_to_pci}));

  assert_inbound_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (bm_to_sys || bm_to_pci) |-> $past(bm_valid));

  assert_claim_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    fwd_claim |-> $past(cpu_valid));

endmodule

bind chunk_window_decoder chunk_window_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHUNK_SHIFT(CHUNK_SHIFT),
  .NUM_CHUNKS(NUM_CHUNKS), .MODE_LSB(MODE_LSB)
) u_chk (
  .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
  .fwd_claim(fwd_claim), .fwd_addr(fwd_addr), .bm_valid(bm_valid),
  .bm_to_sys(bm_to_sys), .bm_to_pci(bm_to_pci),
  .ctrl_q(ctrl_q), .en_q(en_q)
);

// File: tb/chunk_window_decoder_bench.sv
module chunk_window_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] CTRL_OFF = 12'h038;
  localparam logic [11:0] EN_OFF   = 12'h060;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cpu_valid = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        fwd_claim;
  logic [31:0] fwd_addr;
  logic        bm_valid = 1'b0;
  logic [31:0] bm_addr = '0;
  logic        bm_to_sys, bm_to_pci;
  logic [31:0] bm_addr_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chunk_window_decoder u_chunk_window_decoder (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .fwd_claim(fwd_claim), .fwd_addr(fwd_addr),
    .bm_valid(bm_valid), .bm_addr(bm_addr),
    .bm_to_sys(bm_to_sys), .bm_to_pci(bm_to_pci), .bm_addr_out(bm_addr_out)
  );

  // Vector table: control, enable, address, valid, expected claim.
  localparam int NV = 14;
  localparam logic [31:0] V_CTRL [NV] = '{
    32'h80, 32'h80, 32'h80, 32'h0, 32'h100, 32'h180, 32'hFFFFFEFF,
    32'h80, 32'h80, 32'h80, 32'h80, 32'h80, 32'h80, 32'h80};
  localparam logic [31:0] V_EN [NV] = '{
    32'h2, 32'h2, 32'h4000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'h0040_0000, 32'h0040_0000};
  localparam logic [31:0] V_ADDR [NV] = '{
    32'hF080_0010, 32'hF100_0000, 32'hFF7F_FFFC, 32'hF100_0000, 32'hF100_0000,
    32'hF100_0000, 32'hF100_0000, 32'hF000_0000, 32'hFF80_0000, 32'hEFFF_FFFC,
    32'h7080_0000, 32'hF080_0000, 32'hFB00_0004, 32'hFB80_0000};
  localparam bit V_VAL [NV] = '{1,1,1,1,1,1,1,1,1,1,1,0,1,1};
  localparam bit V_EXP [NV] = '{1,0,1,0,0,0,1,0,0,0,0,0,1,0};
  localparam string V_REQ [NV] = '{
    "R4", "R4", "R4", "R5", "R5", "R5", "R5",
    "R6", "R6", "R7", "R7", "R10", "R4", "R4"};

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] off, output logic [31:0] data);
    @(negedge clk);
    cfg_addr = off;
    @(negedge clk);
    data = cfg_rdata;
  endtask

  // Presents one CPU access; the claim is visible after the next edge.
  task automatic cpu(input logic v, input logic [31:0] a, output logic c, output logic [31:0] fa);
    cpu_valid = v; cpu_addr = a;
    @(negedge clk);
    c = fwd_claim; fa = fwd_addr;
    cpu_valid = 1'b0;
  endtask

  task automatic bm(input logic [31:0] a, input bit exp_pci, input string req);
    @(negedge clk);
    bm_valid = 1'b1; bm_addr = a;
    @(negedge clk);
    bm_valid = 1'b0;
    check32(req, {30'd0, bm_to_pci, bm_to_sys}, exp_pci ? 32'd2 : 32'd1);
    check32(req, bm_addr_out, a);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] r;
    logic        c;
    logic [31:0] fa;

    repeat (3) @(negedge clk);
    // R1: reset state
    check32("R1", {31'd0, fwd_claim}, 32'd0);
    rst = 1'b0;
    rd(CTRL_OFF, r); check32("R1", r, 32'd0);
    rd(EN_OFF, r);   check32("R1", r, 32'd0);
    @(negedge clk);
    cpu(1'b1, 32'hF080_0000, c, fa); check32("R1", {31'd0, c}, 32'd0);

    // R2/R3 readback
    wr(EN_OFF, 32'hFFFF_FFFF);
    rd(EN_OFF, r); check32("R2", r, 32'h7FFF_FFFE);
    wr(CTRL_OFF, 32'hFFFF_FEFF);
    rd(CTRL_OFF, r); check32("R3", r, 32'hFFFF_FEFF);

    // R11: stray offsets
    wr(12'h064, 32'h0);
    wr(12'h03C, 32'h0);
    rd(EN_OFF, r);   check32("R11", r, 32'h7FFF_FFFE);
    rd(CTRL_OFF, r); check32("R11", r, 32'hFFFF_FEFF);
    rd(12'h064, r);  check32("R11", r, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      wr(CTRL_OFF, V_CTRL[i]);
      wr(EN_OFF, V_EN[i]);
      cpu(V_VAL[i], V_ADDR[i], c, fa);
      check32(V_REQ[i], {31'd0, c}, {31'd0, V_EXP[i]});
      if (V_EXP[i]) check32(V_REQ[i], fa, V_ADDR[i]);
    end

    // R8: writes take effect for the next access
    wr(CTRL_OFF, 32'h80);
    wr(EN_OFF, 32'h0);
    wr(EN_OFF, 32'h20);
    cpu(1'b1, 32'hF280_0000, c, fa); check32("R8", {31'd0, c}, 32'd1);
    wr(EN_OFF, 32'h0);
    cpu(1'b1, 32'hF280_0000, c, fa); check32("R8", {31'd0, c}, 32'd0);
    wr(EN_OFF, 32'h20);
    wr(CTRL_OFF, 32'h0);
    cpu(1'b1, 32'hF280_0000, c, fa); check32("R8", {31'd0, c}, 32'd0);

    // R9: inbound split
    bm(32'hF07F_FFFC, 1'b0, "R9");
    bm(32'hF080_0000, 1'b1, "R9");
    bm(32'h0000_1000, 1'b0, "R9");
    bm(32'hFFFF_FFFC, 1'b1, "R9");

    // R1: reset mid-run clears both registers
    wr(CTRL_OFF, 32'h80);
    wr(EN_OFF, 32'h2);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(CTRL_OFF, r); check32("R1", r, 32'd0);
    rd(EN_OFF, r);   check32("R1", r, 32'd0);
    cpu(1'b1, 32'hF080_0000, c, fa); check32("R1", {31'd0, c}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule